// File: doc/BRIEF.md
# Elastic Jitter Attenuation Buffer

This block is a one-bit-wide elastic store that smooths a 2.048 Mbit/s serial stream. Incoming bits are qualified by an enable that may be jittered, gapped or bursty. Outgoing bits leave on a strobe made by dividing the 32.768 MHz system clock, so every signal sits in that one clock domain. While the buffer fill stays near its midpoint, the divider runs at 16. When the fill drifts too far in either direction, the divider briefly runs at 15 or 17 to pull the fill back, and a sticky trip flag records each such correction.

Two streams, a receive stream and a transmit stream, pass through the block. A placement input chooses which of the two is buffered, and the other passes straight through without delay. A bypass input sends both streams straight through and freezes the buffer. A depth input chooses between a 128-bit store for large wander and a 32-bit store for low delay. Each change of depth re-centres the buffer.

Top module: `jitter_elastic_store`

## Requirements
- R1: `deep_sel`=1 selects a 128-bit store and `deep_sel`=0 a 32-bit store. Reset holds the 128-bit setting with `fill`=64. After a change to the 32-bit setting, `fill` shows 16.
- R2: While the fill level at every strobe stays within half the limit of the midpoint (60 for 128 bits, 14 for 32 bits), output strobes are exactly 16 clocks apart. This holds for gapped and bursty input and leaves `trip` at 0.
- R3: When a strobe finds the fill more than half the limit above the midpoint (above 124 or above 30), the next strobe comes 15 clocks later.
- R4: When a strobe finds the fill more than half the limit below the midpoint (below 4 or below 2), the next strobe comes 17 clocks later.
- R5: Each 15- or 17-clock correction sets `trip`, which then stays at 1 until a `trip_clr` pulse clears it. A correction in the same cycle as `trip_clr` leaves `trip` at 1.
- R6: Buffered bits leave in the order they were accepted. `fill` rises by one per accepted bit and falls by one per output strobe, and a write and a read in the same cycle leave it unchanged.
- R7: A write to a full store with no read in that cycle is dropped, and `fill` never exceeds the depth. An empty store produces no output strobe, and `fill` stays at 0.
- R8: With `bypass`=1, both outputs equal their inputs combinationally, and `fill` and the divider hold their values.
- R9: `path_tx`=1 buffers the transmit stream and passes the receive stream through. `path_tx`=0 does the reverse. Input on the pass-through stream never changes `fill`.
- R10: A change of `deep_sel` re-centres the store to half the new depth and restarts the divider at 16, so the first output strobe follows 16 clocks after the re-centre.
- R11: Read and write positions wrap modulo the selected depth, and the order of R6 is kept across many wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deep_sel | input | 1 | 1: 128-bit store, 0: 32-bit store |
| path_tx | input | 1 | 1: buffer the transmit stream, 0: buffer the receive stream |
| bypass | input | 1 | 1: both streams pass straight through |
| trip_clr | input | 1 | Clears the trip flag |
| rx_en | input | 1 | Receive input bit qualifier |
| rx_bit | input | 1 | Receive input bit |
| tx_en | input | 1 | Transmit input bit qualifier (may be gapped) |
| tx_bit | input | 1 | Transmit input bit |
| rx_out_en | output | 1 | Receive output bit qualifier |
| rx_out_bit | output | 1 | Receive output bit |
| tx_out_en | output | 1 | Transmit output bit qualifier |
| tx_out_bit | output | 1 | Transmit output bit |
| fill | output | 8 | Current number of bits held |
| trip | output | 1 | Sticky rate-correction flag |

## Verification
The assertions check several properties on every cycle. The fill never passes the depth and never moves by more than one outside a re-centre. Consecutive divider strobes are 15 to 17 clocks apart. A strobe that finds the fill outside the band sets the flag, and the flag holds until cleared. Bypass passes both streams through and freezes the fill. Other behaviour needs the bench's scenarios: bit order across pointer wraps, the exact spacing of 15, 16 or 17 clocks under sustained overfill, underfill and bursty input, the 16-clock restart after a depth change, the clear-versus-set priority, and the routing chosen by `path_tx`.

// File: rtl/jitter_elastic_store.sv
module jitter_elastic_store #(
  parameter int DEEP_BITS     = 128,
  parameter int SHALLOW_BITS  = 32,
  parameter int DEEP_LIMIT    = 120,
  parameter int SHALLOW_LIMIT = 28,
  parameter int NOM_DIV       = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       deep_sel,
  input  logic       path_tx,
  input  logic       bypass,
  input  logic       trip_clr,
  input  logic       rx_en,
  input  logic       rx_bit,
  input  logic       tx_en,
  input  logic       tx_bit,
  output logic       rx_out_en,
  output logic       rx_out_bit,
  output logic       tx_out_en,
  output logic       tx_out_bit,
  output logic [7:0] fill,
  output logic       trip
);
  localparam int AW = $clog2(DEEP_BITS);
  localparam int FW = AW + 1;
  localparam int CW = $clog2(NOM_DIV + 1);

  logic          deep_q;
  logic [FW-1:0] fill_q;
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          buf_stb, buf_bit, trip_q;
  logic          mem [DEEP_BITS];

  logic [FW-1:0] depth, half, hlim, new_half;
  logic [CW-1:0] reload;
  logic          recentre, tick, do_rd, do_wr, in_en, in_bit, hi, lo;

  assign depth    = deep_q ? FW'(DEEP_BITS) : FW'(SHALLOW_BITS);
  assign half     = depth >> 1;
  assign hlim     = deep_q ? FW'(DEEP_LIMIT / 2) : FW'(SHALLOW_LIMIT / 2);
  assign new_half = deep_sel ? FW'(DEEP_BITS / 2) : FW'(SHALLOW_BITS / 2);
  assign recentre = deep_sel != deep_q;

  assign in_en  = path_tx ? tx_en : rx_en;
  assign in_bit = path_tx ? tx_bit : rx_bit;

  assign hi     = fill_q > (half + hlim);
  assign lo     = fill_q < (half - hlim);
  assign reload = hi ? CW'(NOM_DIV - 2) : lo ? CW'(NOM_DIV) : CW'(NOM_DIV - 1);

  assign tick  = (cnt == '0) && !bypass && !recentre;
  assign do_rd = tick && (fill_q != '0);
  assign do_wr = in_en && !bypass && !recentre && ((fill_q != depth) || do_rd);

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p, input logic [FW-1:0] d);
    return (p == AW'(d - 1'b1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= in_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deep_q  <= 1'b1;
      fill_q  <= FW'(DEEP_BITS / 2);
      wp      <= AW'(DEEP_BITS / 2);
      rp      <= '0;
      cnt     <= CW'(NOM_DIV - 1);
      buf_stb <= 1'b0;
      buf_bit <= 1'b0;
    end else if (recentre) begin
      deep_q  <= deep_sel;
      fill_q  <= new_half;
      wp      <= AW'(new_half);
      rp      <= '0;
      cnt     <= CW'(NOM_DIV - 1);
      buf_stb <= 1'b0;
    end else if (bypass) begin
      buf_stb <= 1'b0;
    end else begin
      cnt     <= tick ? reload : cnt - 1'b1;
      fill_q  <= fill_q + FW'(do_wr) - FW'(do_rd);
      buf_stb <= do_rd;
      if (do_rd) begin
        buf_bit <= mem[rp];
        rp      <= wrap_inc(rp, depth);
      end
      if (do_wr) wp <= wrap_inc(wp, depth);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  trip_q <= 1'b0;
    else if (tick && reload != CW'(NOM_DIV - 1)) trip_q <= 1'b1;
    else if (trip_clr)                           trip_q <= 1'b0;
  end

  assign rx_out_en  = (bypass || path_tx)  ? rx_en  : buf_stb;
  assign rx_out_bit = (bypass || path_tx)  ? rx_bit : buf_bit;
  assign tx_out_en  = (bypass || !path_tx) ? tx_en  : buf_stb;
  assign tx_out_bit = (bypass || !path_tx) ? tx_bit : buf_bit;
  assign fill       = 8'(fill_q);
  assign trip       = trip_q;
endmodule

module jitter_elastic_store_chk #(
  parameter int DEEP_BITS     = 128,
  parameter int SHALLOW_BITS  = 32,
  parameter int DEEP_LIMIT    = 120,
  parameter int SHALLOW_LIMIT = 28
) (
  input logic       clk,
  input logic       rst_n,
  input logic       deep_sel,
  input logic       deep_q,
  input logic       tick,
  input logic       bypass,
  input logic       trip_clr,
  input logic [7:0] fill,
  input logic       trip,
  input logic       rx_en,
  input logic       rx_bit,
  input logic       tx_en,
  input logic       tx_bit,
  input logic       rx_out_en,
  input logic       rx_out_bit,
  input logic       tx_out_en,
  input logic       tx_out_bit
);
  logic [8:0] dep, mid, hl;
  logic       rc;
  logic [5:0] gap;

  assign dep = deep_q ? 9'(DEEP_BITS) : 9'(SHALLOW_BITS);
  assign mid = dep >> 1;
  assign hl  = deep_q ? 9'(DEEP_LIMIT / 2) : 9'(SHALLOW_LIMIT / 2);
  assign rc  = deep_sel != deep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gap <= '0;
    else if (rc || bypass)       gap <= '0;
    else if (tick)               gap <= 6'd1;
    else if (gap != '0 && gap != '1) gap <= gap + 1'b1;
  end

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    9'(fill) <= dep);

  assert_fill_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rc |=> (fill == $past(fill) || fill == $past(fill) + 8'd1 || fill + 8'd1 == $past(fill)));

  assert_recentre_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rc |=> (9'(fill) == mid && gap == '0));

  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && gap != '0) |-> (gap >= 6'd15 && gap <= 6'd17));

  assert_trip_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && !trip_clr) |=> trip);

  assert_trip_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && 9'(fill) > mid + hl) |=> trip);

  assert_trip_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && 9'(fill) < mid - hl) |=> trip);

  assert_bypass_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (rx_out_en == rx_en && rx_out_bit == rx_bit &&
                tx_out_en == tx_en && tx_out_bit == tx_bit));

  assert_bypass_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !rc) |=> $stable(fill));
endmodule

bind jitter_elastic_store jitter_elastic_store_chk #(
  .DEEP_BITS(DEEP_BITS), .SHALLOW_BITS(SHALLOW_BITS),
  .DEEP_LIMIT(DEEP_LIMIT), .SHALLOW_LIMIT(SHALLOW_LIMIT)
) chk (
  .clk(clk), .rst_n(rst_n), .deep_sel(deep_sel), .deep_q(deep_q), .tick(tick),
  .bypass(bypass), .trip_clr(trip_clr), .fill(fill), .trip(trip),
  .rx_en(rx_en), .rx_bit(rx_bit), .tx_en(tx_en), .tx_bit(tx_bit),
  .rx_out_en(rx_out_en), .rx_out_bit(rx_out_bit),
  .tx_out_en(tx_out_en), .tx_out_bit(tx_out_bit)
);

// File: tb/jitter_elastic_store_test.sv
module jitter_elastic_store_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic deep_sel = 1'b1, path_tx = 1'b1, bypass = 1'b0, trip_clr = 1'b0;
  logic rx_en = 1'b0, rx_bit = 1'b0, tx_en = 1'b0, tx_bit = 1'b0;
  logic rx_out_en, rx_out_bit, tx_out_en, tx_out_bit, trip;
  logic [7:0] fill;

  always #2 clk = ~clk;

  jitter_elastic_store uut (
    .clk(clk), .rst_n(rst_n), .deep_sel(deep_sel), .path_tx(path_tx), .bypass(bypass),
    .trip_clr(trip_clr), .rx_en(rx_en), .rx_bit(rx_bit), .tx_en(tx_en), .tx_bit(tx_bit),
    .rx_out_en(rx_out_en), .rx_out_bit(rx_out_bit), .tx_out_en(tx_out_en),
    .tx_out_bit(tx_out_bit), .fill(fill), .trip(trip)
  );

  int total = 0, bad = 0;
  int cyc = 0, last_stb = -1, f_exp = 0;
  int n15 = 0, n16 = 0, n17 = 0, nother = 0;
  bit track = 1'b1, check_data = 1'b1;
  bit qv [8192];
  bit qc [8192];
  int qh = 0, qt = 0;
  bit seen;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset(input int h);
    qh = 0; qt = h; f_exp = h; last_stb = -1;
    for (int i = 0; i < h; i++) qc[i] = 1'b0;
  endtask

  task automatic clear_tally();
    n15 = 0; n16 = 0; n17 = 0; nother = 0;
  endtask

  task automatic step(input bit en, input bit b);
    logic bo_en, bo_bit;
    if (path_tx) begin tx_en = en; tx_bit = b; end
    else begin rx_en = en; rx_bit = b; end
    @(negedge clk);
    cyc++;
    if (en && !bypass) begin
      f_exp++;
      qv[qt % 8192] = b; qc[qt % 8192] = 1'b1; qt++;
    end
    bo_en  = path_tx ? tx_out_en : rx_out_en;
    bo_bit = path_tx ? tx_out_bit : rx_out_bit;
    seen = bo_en;
    if (bo_en) begin
      f_exp--;
      if (last_stb >= 0) begin
        case (cyc - last_stb)
          15: n15++;
          16: n16++;
          17: n17++;
          default: nother++;
        endcase
      end
      last_stb = cyc;
      if (qh < qt) begin
        if (check_data && qc[qh % 8192])
          check(bo_bit == qv[qh % 8192], "R6 R11 order", int'(bo_bit), int'(qv[qh % 8192]));
        qh++;
      end
    end
    if (track) check(int'(fill) == f_exp, "R6 fill", int'(fill), f_exp);
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f0;
    bit t0, got;
    repeat (3) @(negedge clk);
    check(fill == 8'd64, "R1 reset fill", int'(fill), 64);
    check(trip == 1'b0, "R5 reset trip", int'(trip), 0);
    check(tx_out_en == 1'b0, "R1 reset strobe", int'(tx_out_en), 0);
    rst_n = 1'b1;
    model_reset(64);

    // R2 R6 R11: steady rate, one bit every 16 clocks
    clear_tally();
    for (int k = 0; k < 200; k++)
      for (int j = 0; j < 16; j++) step(j == 0, ((k * 7 + 3) % 5) < 2);
    check(n16 > 150 && n15 == 0 && n17 == 0 && nother == 0, "R2 steady spacing", n15 + n17 + nother, 0);
    check(trip == 1'b0, "R2 steady trip", int'(trip), 0);

    // R2: bursty input of the same average rate
    clear_tally();
    for (int k = 0; k < 8; k++)
      for (int j = 0; j < 256; j++) step(j < 16, ((k + j) % 3) == 0);
    check(n16 > 100 && n15 == 0 && n17 == 0 && nother == 0, "R2 bursty spacing", n15 + n17 + nother, 0);
    check(trip == 1'b0, "R2 bursty trip", int'(trip), 0);

    // R3 R5: overfill
    clear_tally();
    while (f_exp < 127) step(1'b1, f_exp[0]);
    repeat (160) step(1'b0, 1'b0);
    check(n15 > 0 && n17 == 0, "R3 short periods", n15, 1);
    check(trip == 1'b1, "R5 trip set high", int'(trip), 1);
    trip_clr = 1'b1; step(1'b0, 1'b0); trip_clr = 1'b0;
    check(trip == 1'b0, "R5 trip clear", int'(trip), 0);
    step(1'b0, 1'b0);
    check(trip == 1'b0, "R5 trip stays clear", int'(trip), 0);

    // R5: set wins over a held clear
    while (f_exp < 127) step(1'b1, 1'b1);
    trip_clr = 1'b1;
    for (int i = 0; i < 60; i++) begin
      step(1'b0, 1'b0);
      if (seen && f_exp >= 124) check(trip == 1'b1, "R5 set over clear", int'(trip), 1);
    end
    trip_clr = 1'b0;
    step(1'b0, 1'b0);

    // R10 R1: depth change re-centres, first strobe 16 clocks on
    trip_clr = 1'b1; step(1'b0, 1'b0); trip_clr = 1'b0;
    deep_sel = 1'b0;
    model_reset(16);
    for (int i = 1; i <= 17; i++) begin
      step(1'b0, 1'b0);
      if (i == 1) check(fill == 8'd16, "R1 R10 recentre fill", int'(fill), 16);
      check(seen == (i == 17), "R10 first strobe", int'(seen), int'(i == 17));
    end
    check(trip == 1'b0, "R10 divider nominal", int'(trip), 0);

    // R4: underfill in the 32-bit store
    while (f_exp > 1) step(1'b0, 1'b0);
    clear_tally();
    for (int r = 0; r < 8; r++) begin
      got = 1'b0;
      for (int i = 0; i < 40 && !got; i++) begin
        step(1'b0, 1'b0);
        got = seen;
      end
      step(1'b1, r[0]);
    end
    check(n17 >= 6 && n15 == 0, "R4 long periods", n17, 6);
    check(trip == 1'b1, "R4 trip set low", int'(trip), 1);

    // R7: empty store gives no strobe
    repeat (20) step(1'b0, 1'b0);
    got = 1'b0;
    for (int i = 0; i < 180; i++) begin
      step(1'b0, 1'b0);
      got = got | seen;
    end
    check(got == 1'b0, "R7 empty no strobe", int'(got), 0);
    check(fill == 8'd0, "R7 empty fill", int'(fill), 0);

    // R7: full store drops writes
    track = 1'b0; check_data = 1'b0;
    for (int i = 0; i < 100; i++) begin
      step(1'b1, 1'b1);
      if (fill > 8'd32) check(1'b0, "R7 bound", int'(fill), 32);
    end
    check(fill == 8'd32, "R7 full fill", int'(fill), 32);

    // R8: bypass
    f0 = int'(fill); t0 = trip;
    bypass = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tx_en = (i % 3) == 0; tx_bit = i[0]; rx_en = (i % 4) == 1; rx_bit = i[1];
      #1;
      check(tx_out_en == tx_en && tx_out_bit == tx_bit, "R8 tx pass", int'({tx_out_en, tx_out_bit}), int'({tx_en, tx_bit}));
      check(rx_out_en == rx_en && rx_out_bit == rx_bit, "R8 rx pass", int'({rx_out_en, rx_out_bit}), int'({rx_en, rx_bit}));
      @(negedge clk);
      check(int'(fill) == f0, "R8 frozen fill", int'(fill), f0);
    end
    check(trip == t0, "R8 trip held", int'(trip), int'(t0));
    bypass = 1'b0; tx_en = 1'b0; rx_en = 1'b0;

    // R9: receive stream buffered, transmit passes through
    path_tx = 1'b0;
    f_exp = int'(fill);
    got = 1'b0;
    for (int i = 0; i < 64; i++) begin
      tx_en = 1'b1; tx_bit = i[2]; rx_en = 1'b0;
      #1;
      check(tx_out_en == 1'b1 && tx_out_bit == tx_bit, "R9 tx direct", int'({tx_out_en, tx_out_bit}), int'({1'b1, tx_bit}));
      @(negedge clk);
      if (rx_out_en) begin got = 1'b1; f_exp--; end
    end
    check(got == 1'b1, "R9 rx buffered", int'(got), 1);
    check(int'(fill) == f_exp, "R9 fill ignores tx", int'(fill), f_exp);
    tx_en = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule